// File: doc/BRIEF.md
# Deadline-Slack Supply Level Selector

This block sits behind a deadline sorter and a slack calculator in a multi-engine crypto accelerator. Descriptors arrive earliest deadline first. Each one carries its compute time at the low and at the high supply level, the cost of changing the level, and two slack bounds: one worked out as if every later descriptor ran low, one as if every later descriptor ran high. For each descriptor the block decides one of four outcomes. It can place the descriptor on the low level or on the high level of the current engine. It can hand the descriptor to an external arbitration helper when the low level fits only the more generous bound. It can spill the descriptor to the overflow list for the next engine.

Descriptors come in passes, and the final descriptor of each pass is flagged. When a pass ends with at least one spilled descriptor, the block moves on to the next engine, and the upstream logic replays the spilled descriptors as a new pass. If that happens on the final engine, the block raises a sticky failure instead. When a pass ends with nothing spilled, the schedule is complete. The block then presents a power-gate mask that keeps every engine above the current one switched off.

Top module: `vlevel_sched`

## Requirements
- R1: If c_lo + ovh (computed at 17 bits, no wrap) is at most slk_lo, the result is low level: out_valid=1, out_hi=0, out_defer=0, one cycle after the input handshake.
- R2: If c_lo + ovh exceeds slk_lo but is at most slk_hi, dec_valid rises one cycle after the input handshake and holds until dec_ready. The result then appears one cycle after the dec handshake, with out_hi equal to dec_hi (1 = high).
- R3: If c_lo + ovh exceeds slk_hi and c_hi + ovh is at most slk_hi, the result is high level: out_hi=1, out_defer=0.
- R4: If c_hi + ovh exceeds slk_hi, the result has out_defer=1 and out_hi=0. Every result carries out_eng, the engine that processed the descriptor.
- R5: Every comparison is unsigned and uses less-or-equal, so an exact tie takes the cheaper outcome.
- R6: A pass whose final descriptor (in_last=1) resolves while any descriptor of that pass was deferred advances eng_idx by one. This takes effect in the cycle its result is shown, and eng_idx never goes past NENG-1.
- R7: Such a pass ending on engine NENG-1 sets fail, which stays set until reset. in_ready is held low after that.
- R8: A pass ending with no deferral sets done. gate_mask bit i is then 1 exactly for i > eng_idx, and in_ready is held low. gate_mask is all zero while done is 0.
- R9: in_ready is low while an arbitration request is pending. Each accepted descriptor yields exactly one single-cycle out_valid, in arrival order.
- R10: After reset: in_ready=1, out_valid=0, dec_valid=0, eng_idx=0, fail=0, done=0, gate_mask=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| in_last | input | 1 | Final descriptor of the current pass |
| in_c_lo | input | TW | Compute time at low level |
| in_c_hi | input | TW | Compute time at high level |
| in_ovh | input | TW | Level change overhead |
| in_slk_lo | input | TW | Slack bound, all-low assumption |
| in_slk_hi | input | TW | Slack bound, all-high assumption |
| dec_valid | output | 1 | Arbitration request pending |
| dec_ready | input | 1 | Helper answer present |
| dec_hi | input | 1 | Helper choice, 1 = high level |
| out_valid | output | 1 | Result pulse |
| out_hi | output | 1 | Result level, 1 = high |
| out_defer | output | 1 | Descriptor spilled to next engine |
| out_eng | output | EW | Engine that processed the descriptor |
| eng_idx | output | EW | Current engine |
| fail | output | 1 | Schedule failure, sticky |
| done | output | 1 | Schedule complete, sticky |
| gate_mask | output | NENG | Engines kept power-gated, valid with done |

## Verification
Per-descriptor result reporting and end-of-pass bookkeeping happen in the same cycle. When the flagged final descriptor resolves, its result pulse comes out together with the engine step, the failure flag, or the done flag and gate mask. The bench provokes the hardest overlap: a final descriptor that is itself deferred on the last engine, so the defer pulse and the failure must rise together. It also ends passes whose final descriptor goes through the helper after a stall. At that one sampled cycle it judges the result fields against the old engine index and the pass-end state against the new one.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic [1:0] {
    CLS_LO  = 2'd0,
    CLS_AMB = 2'd1,
    CLS_HI  = 2'd2,
    CLS_DEF = 2'd3
  } vls_cls_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_ARB  = 2'd1
  } vls_st_e;

endpackage

// File: rtl/vls_classify.sv
module vls_classify
  import vls_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic [TW-1:0] c_lo,
  input  logic [TW-1:0] c_hi,
  input  logic [TW-1:0] ovh,
  input  logic [TW-1:0] slk_lo,
  input  logic [TW-1:0] slk_hi,
  output vls_cls_e      cls
);
  localparam int SW = TW + 1;

  logic [SW-1:0] need_lo;
  logic [SW-1:0] need_hi;
  logic          fit_lo_lo;
  logic          fit_lo_hi;
  logic          fit_hi_hi;

  always_comb begin
    need_lo   = {1'b0, c_lo} + {1'b0, ovh};
    need_hi   = {1'b0, c_hi} + {1'b0, ovh};
    fit_lo_lo = need_lo <= {1'b0, slk_lo};
    fit_lo_hi = need_lo <= {1'b0, slk_hi};
    fit_hi_hi = need_hi <= {1'b0, slk_hi};
    if (fit_lo_lo)      cls = CLS_LO;
    else if (fit_lo_hi) cls = CLS_AMB;
    else if (fit_hi_hi) cls = CLS_HI;
    else                cls = CLS_DEF;
  end

endmodule

// File: rtl/vls_eng_track.sv
module vls_eng_track #(
  parameter int NENG = 4,
  parameter int EW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            res_fire,
  input  logic            res_defer,
  input  logic            res_last,
  output logic [EW-1:0]   eng,
  output logic            fail,
  output logic            done,
  output logic [NENG-1:0] gate_mask
);
  localparam logic [EW-1:0] ENG_TOP = EW'(NENG - 1);

  logic            pass_def;
  logic            any_def;
  logic [NENG-1:0] above;

  assign any_def = pass_def | res_defer;

  for (genvar i = 0; i < NENG; i++) begin : g_above
    assign above[i] = (EW'(i) > eng) && (i < NENG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eng       <= '0;
      fail      <= 1'b0;
      done      <= 1'b0;
      gate_mask <= '0;
      pass_def  <= 1'b0;
    end else if (res_fire) begin
      if (res_last) begin
        pass_def <= 1'b0;
        if (any_def) begin
          if (eng == ENG_TOP) fail <= 1'b1;
          else                eng  <= eng + 1'b1;
        end else begin
          done      <= 1'b1;
          gate_mask <= above;
        end
      end else if (res_defer) begin
        pass_def <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
#(
  parameter int EW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt,
  input  logic          in_valid,
  input  logic          in_last,
  input  vls_cls_e      cls,
  input  logic [EW-1:0] eng,
  output logic          in_ready,
  output logic          dec_valid,
  input  logic          dec_ready,
  input  logic          dec_hi,
  output logic          res_fire,
  output logic          res_defer,
  output logic          res_last,
  output logic          out_valid,
  output logic          out_hi,
  output logic          out_defer,
  output logic [EW-1:0] out_eng
);
  vls_st_e st;
  logic    hold_last;
  logic    acc;
  logic    dec_fire;
  logic    res_hi;

  assign in_ready = (st == ST_RUN) && !halt;
  assign acc      = in_valid && in_ready;
  assign dec_fire = dec_valid && dec_ready;

  always_comb begin
    res_fire  = 1'b0;
    res_defer = 1'b0;
    res_hi    = 1'b0;
    res_last  = 1'b0;
    if (dec_fire) begin
      res_fire = 1'b1;
      res_hi   = dec_hi;
      res_last = hold_last;
    end else if (acc && cls != CLS_AMB) begin
      res_fire  = 1'b1;
      res_hi    = (cls == CLS_HI);
      res_defer = (cls == CLS_DEF);
      res_last  = in_last;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RUN;
      hold_last <= 1'b0;
      dec_valid <= 1'b0;
      out_valid <= 1'b0;
      out_hi    <= 1'b0;
      out_defer <= 1'b0;
      out_eng   <= '0;
    end else begin
      out_valid <= res_fire;
      out_hi    <= res_fire && res_hi;
      out_defer <= res_fire && res_defer;
      if (res_fire) out_eng <= eng;
      if (acc && cls == CLS_AMB) begin
        st        <= ST_ARB;
        hold_last <= in_last;
        dec_valid <= 1'b1;
      end else if (dec_fire) begin
        st        <= ST_RUN;
        dec_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vlevel_sched.sv
module vlevel_sched
  import vls_pkg::*;
#(
  parameter int TW   = 16,
  parameter int NENG = 4,
  parameter int EW   = (NENG > 1) ? $clog2(NENG) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_last,
  input  logic [TW-1:0]   in_c_lo,
  input  logic [TW-1:0]   in_c_hi,
  input  logic [TW-1:0]   in_ovh,
  input  logic [TW-1:0]   in_slk_lo,
  input  logic [TW-1:0]   in_slk_hi,
  output logic            dec_valid,
  input  logic            dec_ready,
  input  logic            dec_hi,
  output logic            out_valid,
  output logic            out_hi,
  output logic            out_defer,
  output logic [EW-1:0]   out_eng,
  output logic [EW-1:0]   eng_idx,
  output logic            fail,
  output logic            done,
  output logic [NENG-1:0] gate_mask
);
  vls_cls_e cls;
  logic     res_fire;
  logic     res_defer;
  logic     res_last;
  logic     halt;

  assign halt = fail | done;

  vls_classify #(.TW(TW)) u_cls (
    .c_lo(in_c_lo), .c_hi(in_c_hi), .ovh(in_ovh),
    .slk_lo(in_slk_lo), .slk_hi(in_slk_hi), .cls(cls)
  );

  vls_ctrl #(.EW(EW)) u_ctrl (
    .clk(clk), .rst(rst), .halt(halt),
    .in_valid(in_valid), .in_last(in_last), .cls(cls), .eng(eng_idx),
    .in_ready(in_ready), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_hi(dec_hi), .res_fire(res_fire), .res_defer(res_defer),
    .res_last(res_last), .out_valid(out_valid), .out_hi(out_hi),
    .out_defer(out_defer), .out_eng(out_eng)
  );

  vls_eng_track #(.NENG(NENG), .EW(EW)) u_trk (
    .clk(clk), .rst(rst), .res_fire(res_fire), .res_defer(res_defer),
    .res_last(res_last), .eng(eng_idx), .fail(fail), .done(done),
    .gate_mask(gate_mask)
  );

endmodule

// File: rtl/vls_chk.sv
module vls_chk #(
  parameter int NENG = 4,
  parameter int EW   = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            dec_valid,
  input logic            dec_ready,
  input logic            out_valid,
  input logic            out_hi,
  input logic            out_defer,
  input logic [EW-1:0]   eng_idx,
  input logic            fail,
  input logic            done
  ,
  input logic [NENG-1:0] gate_mask
);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !dec_ready |=> dec_valid);

  a_r9_no_accept_in_arb: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> !in_ready);

  a_r9_result_vs_req: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, dec_valid}));

  a_r4_defer_is_low: assert property (@(posedge clk) disable iff (rst)
    out_defer |-> out_valid && !out_hi);

  a_r6_eng_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (eng_idx == $past(eng_idx)) || (eng_idx == $past(eng_idx) + 1'b1));

  a_r6_eng_bound: assert property (@(posedge clk) disable iff (rst)
    int'(eng_idx) <= NENG - 1);

  a_r7_fail_on_top: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> int'(eng_idx) == NENG - 1);

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    fail |=> fail && !in_ready);

  a_r8_mask_idle: assert property (@(posedge clk) disable iff (rst)
    !done |-> gate_mask == '0);

  a_r8_own_engine_on: assert property (@(posedge clk) disable iff (rst)
    done |-> !gate_mask[eng_idx]);
endmodule

bind vlevel_sched vls_chk #(.NENG(NENG), .EW(EW)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .dec_valid(dec_valid),
  .dec_ready(dec_ready), .out_valid(out_valid), .out_hi(out_hi),
  .out_defer(out_defer), .eng_idx(eng_idx), .fail(fail), .done(done),
  .gate_mask(gate_mask)
);

// File: tb/sim_vlevel_sched.sv
`timescale 1ns/1ps
module sim_vlevel_sched;
  localparam int TW = 16;
  localparam int NENG = 4;
  localparam int EW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [TW-1:0] c_lo = '0, c_hi = '0, ovh = '0, sl = '0, sh = '0;
  logic dec_ready = 1'b0, dec_hi = 1'b0;
  logic in_ready, dec_valid, out_valid, out_hi, out_defer, fail, done;
  logic [EW-1:0] out_eng, eng_idx;
  logic [NENG-1:0] gate_mask;

  int n_run = 0, n_bad = 0;
  int m_eng;
  bit m_pdef, m_fail, m_done;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vlevel_sched #(.TW(TW), .NENG(NENG)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_c_lo(c_lo), .in_c_hi(c_hi), .in_ovh(ovh),
    .in_slk_lo(sl), .in_slk_hi(sh), .dec_valid(dec_valid),
    .dec_ready(dec_ready), .dec_hi(dec_hi), .out_valid(out_valid),
    .out_hi(out_hi), .out_defer(out_defer), .out_eng(out_eng),
    .eng_idx(eng_idx), .fail(fail), .done(done), .gate_mask(gate_mask)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 low, 1 arbitrate, 2 high, 3 defer
  function automatic int model_cls(int a, int b, int o, int l, int h);
    if (a + o <= l) return 0;
    if (a + o <= h) return 1;
    if (b + o <= h) return 2;
    return 3;
  endfunction

  function automatic int model_mask(int e);
    int m = 0;
    for (int i = 0; i < NENG; i++) if (i > e) m |= (1 << i);
    return m;
  endfunction

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; dec_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    m_eng = 0; m_pdef = 0; m_fail = 0; m_done = 0;
    chk(in_ready && !out_valid && !dec_valid, "R10 idle", {in_ready, out_valid, dec_valid}, 4);
    chk(eng_idx == 0 && !fail && !done && gate_mask == 0, "R10 state",
        {eng_idx, fail, done, gate_mask}, 0);
  endtask

  task automatic send(input int a, b, o, l, h, input bit last, input bit dhi, input int dwait);
    int cls, exp_hi, exp_eng;
    c_lo = TW'(a); c_hi = TW'(b); ovh = TW'(o); sl = TW'(l); sh = TW'(h);
    in_last = last; in_valid = 1'b1;
    chk(in_ready == 1'b1, "R9 ready before accept", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cls = model_cls(a, b, o, l, h);
    exp_eng = m_eng;
    if (cls == 1) begin
      chk(dec_valid && !out_valid, "R2 request raised", {dec_valid, out_valid}, 2);
      for (int k = 0; k < dwait; k++) begin
        @(negedge clk);
        chk(dec_valid && !in_ready && !out_valid, "R9 stall during request",
            {dec_valid, in_ready, out_valid}, 4);
      end
      dec_ready = 1'b1; dec_hi = dhi;
      @(posedge clk);
      @(negedge clk);
      dec_ready = 1'b0;
      exp_hi = dhi;
    end else begin
      exp_hi = (cls == 2);
    end
    chk(out_valid == 1'b1, "R9 one result", out_valid, 1);
    chk(out_hi == exp_hi[0], cls == 0 ? "R1 low" : cls == 2 ? "R3 high" : cls == 1 ? "R2 helper" : "R4 defer hi",
        out_hi, exp_hi);
    chk(out_defer == (cls == 3), "R4 defer flag", out_defer, cls == 3);
    chk(out_eng == EW'(exp_eng), "R4 engine tag", out_eng, exp_eng);
    if (cls == 3) m_pdef = 1;
    if (last) begin
      if (m_pdef) begin
        if (m_eng == NENG - 1) m_fail = 1; else m_eng++;
      end else m_done = 1;
      m_pdef = 0;
      chk(eng_idx == EW'(m_eng), "R6 engine index", eng_idx, m_eng);
      chk(fail == m_fail, "R7 fail", fail, m_fail);
      chk(done == m_done, "R8 done", done, m_done);
      chk(gate_mask == (m_done ? NENG'(model_mask(m_eng)) : '0), "R8 gate mask",
          gate_mask, m_done ? model_mask(m_eng) : 0);
      if (m_fail || m_done) begin
        chk(!in_ready, "R7 R8 halted", in_ready, 0);
        @(negedge clk);
        chk(!out_valid && !in_ready, "R9 no extra result", {out_valid, in_ready}, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(1234));
    do_reset();
    // R5 ties: exact fit on low bound, on high bound, on high compute
    send(10, 5, 2, 12, 20, 0, 0, 0);      // R1 R5 low tie
    send(10, 5, 2, 11, 12, 0, 1, 2);      // R2 R5 tie on high bound
    send(10, 5, 3, 9, 8, 0, 0, 0);        // R3 R5 high tie
    send(65535, 65535, 65535, 65535, 65535, 1, 0, 0); // R4 R5 no wrap, defer -> R6
    // engines 1..3: single deferred descriptor each, last one fails with defer pulse
    send(50, 40, 1, 0, 0, 1, 0, 0);
    send(50, 40, 1, 0, 0, 1, 0, 0);
    send(50, 40, 1, 0, 0, 1, 0, 0);       // R7 defer and fail together
    do_reset();
    send(3, 1, 1, 10, 20, 0, 0, 0);
    send(8, 4, 1, 5, 12, 1, 0, 3);        // R8 done at engine 0 via helper
    do_reset();
    send(30, 20, 1, 5, 10, 1, 0, 0);      // defer -> engine 1
    send(4, 2, 0, 4, 9, 1, 0, 0);         // R8 done at engine 1
    for (int it = 0; it < 60; it++) begin
      do_reset();
      while (!m_fail && !m_done) begin
        int len = 1 + int'($urandom_range(5));
        for (int j = 0; j < len; j++) begin
          int a = int'($urandom_range(30));
          int o = int'($urandom_range(5));
          int l = int'($urandom_range(40));
          int h = l + int'($urandom_range(30));
          if (m_fail || m_done) break;
          send(a, a / 2, o, l, h, j == len - 1, 1'($urandom_range(1)),
               int'($urandom_range(3)));
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule